// File: doc/BRIEF.md
# Buffered-Reload Three-Channel PWM Timer

A 16-bit up-counter that produces three pulse-width-modulated outputs sharing one period, plus a square-wave output that changes level once per period. Software writes four holding registers through a small write port: address 0 holds the period, and addresses 1 to 3 hold the duty values of outputs 0 to 2. The counter never compares against the holding registers directly. It compares against a set of active buffers, so a half-written configuration can never reach the outputs.

The buffers copy the holding registers at a period match, but only when a reload has been armed. Only a write to address 1 arms a reload, and a completed reload disarms it. To change the period alone, software writes the new period and then writes address 1 again with its old duty value. A count-enable input starts and stops the timer. A rising edge of count-enable restarts the counter from zero and loads the buffers directly. A single-cycle clock-enable input paces the counting.

Top module: `pwm_reload_timer`

## Requirements
- R1: While running and ticking, the counter steps from 0 up to the period buffer and returns to 0 on the next tick after it equals the period buffer. `per_tgl` changes level at each such period match.
- R2: PWM output k is high while the counter is below duty buffer k+1 and low otherwise. A duty of 0 keeps the output low for the whole period. A duty above the period keeps it high for the whole period.
- R3: Writes to the holding registers (address 0 = period, addresses 1..3 = duty of outputs 0..2) change neither the buffers nor the outputs until a reload or a restart.
- R4: At a period match the buffers reload only if address 1 was written since the last reload or restart. A write to address 0 alone does not arm the reload.
- R5: A reload copies all four holding registers into the buffers at once and clears the armed state.
- R6: Writes made while `run` is 0 are ignored.
- R7: In the cycle when `run` rises, all outputs are low. At the next edge the counter is cleared, the buffers are loaded from the holding registers, the toggle level is reset to low and the armed state is cleared.
- R8: While `run` is 0 the counter is held at 0, and all PWM outputs and `per_tgl` are low from the next cycle on.
- R9: When `tick` is 0 the counter, the toggle level and the buffers hold.
- R10: A write to address 1 in the same cycle as an armed period match does two things. The reload uses the holding values from before that write. The armed state stays set, so the new value is loaded at the following match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count clock-enable |
| run | input | 1 | Count enable; a rising edge restarts the timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1..3 duty |
| wr_data | input | 16 | Write data |
| pwm_out | output | 3 | PWM outputs |
| per_tgl | output | 1 | Level that changes at each period match |

## Verification
Two events can fall in the same cycle: a write to the arming register and an armed period match. The reload and the arming write then compete for the same state. The bench keeps its own count of the counter. It waits for a negative edge at which that count equals the buffered period, and drives the address-1 write there. The reference model then expects the old duty to appear in the next period and the new duty in the period after it. The same collision is provoked with a restart edge, where a write in the start cycle must leave the reload armed.

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
  parameter int CW  = 16,
  parameter int NCH = 3,
  localparam int NREG = NCH + 1,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [NCH-1:0] pwm_out,
  output logic          per_tgl
);

  logic [NREG-1:0][CW-1:0] hold_q, buf_q;
  logic [CW-1:0] cnt_q;
  logic run_q, arm_q, tgl_q;

  wire start    = run & ~run_q;
  wire counting = run & run_q & tick;
  wire match    = counting & (cnt_q == buf_q[0]);
  wire reload   = match & arm_q;
  wire wr_ok    = run & wr_en & (int'(wr_addr) < NREG);
  wire arm_wr   = wr_ok & (wr_addr == AW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      buf_q <= '0;
      run_q <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      run_q <= run;
      if (start) begin
        cnt_q <= '0;
        tgl_q <= 1'b0;
        buf_q <= hold_q;
      end else if (!run) begin
        cnt_q <= '0;
      end else if (counting) begin
        if (match) begin
          cnt_q <= '0;
          tgl_q <= ~tgl_q;
          if (arm_q) buf_q <= hold_q;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      if (wr_ok) hold_q[wr_addr] <= wr_data;
      if (arm_wr) arm_q <= 1'b1;
      else if (start || reload) arm_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_pwm
    assign pwm_out[k] = run_q & (cnt_q < buf_q[k+1]);
  end
  assign per_tgl = run_q & tgl_q;

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> cnt_q == '0);
  p_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> tgl_q != $past(tgl_q));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !start) |=> $stable(buf_q));
  p_noarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !arm_q) |=> $stable(buf_q));
  p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !arm_wr) |=> !arm_q);
  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(hold_q));
  p_start_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (pwm_out == '0 && !per_tgl));
  p_start_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0 && buf_q == $past(hold_q)));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pwm_out == '0 && !per_tgl && cnt_q == '0));
  p_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && run_q && !tick) |=> ($stable(cnt_q) && $stable(tgl_q)));
  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && arm_wr) |=> (arm_q && buf_q == $past(hold_q)));

endmodule

// File: tb/pwm_reload_timer_bench.sv
module pwm_reload_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, run = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0] pwm_out;
  logic per_tgl;

  pwm_reload_timer u_pwm_reload_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .per_tgl(per_tgl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string phase = "R8 reset";

  int m_reg [4];
  int m_buf [4];
  int m_cnt = 0;
  bit m_runq = 0, m_arm = 0, m_tgl = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[i]) begin m_reg[i] = 0; m_buf[i] = 0; end
      m_cnt = 0; m_runq = 0; m_arm = 0; m_tgl = 0;
    end else begin
      bit go, hit;
      int pre [4];
      foreach (m_reg[i]) pre[i] = m_reg[i];
      go  = run && !m_runq;
      hit = m_runq && run && tick && (m_cnt == m_buf[0]);
      if (go) begin
        m_cnt = 0; m_tgl = 0; m_arm = 0;
        foreach (m_buf[i]) m_buf[i] = pre[i];
      end else if (!run) begin
        m_cnt = 0;
      end else if (m_runq && tick) begin
        if (hit) begin
          m_cnt = 0; m_tgl = !m_tgl;
          if (m_arm) begin
            foreach (m_buf[i]) m_buf[i] = pre[i];
            m_arm = 0;
          end
        end else m_cnt = m_cnt + 1;
      end
      if (run && wr_en) begin
        m_reg[wr_addr] = wr_data;
        if (wr_addr == 2'd1) m_arm = 1;
      end
      m_runq = run;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    for (int k = 0; k < 3; k++) begin
      bit e;
      e = m_runq && (m_cnt < m_buf[k+1]);
      check($sformatf("%s pwm%0d", phase, k), int'(pwm_out[k]), int'(e));
    end
    check($sformatf("%s toggle", phase), int'(per_tgl), int'(m_runq && m_tgl));
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    phase = "R6 write while stopped";
    wr(1, 5);
    idle(2);
    phase = "R7 start";
    @(negedge clk); run = 1'b1; tick = 1'b1;
    idle(2);
    phase = "R3 holding writes";
    wr(0, 9); wr(2, 0); wr(3, 12);
    idle(3);
    wr(1, 3);
    phase = "R1 R2 R5 reload and run";
    idle(40);
    phase = "R4 period-only write";
    wr(0, 5);
    idle(30);
    phase = "R4 arming write";
    wr(1, 3);
    idle(30);
    phase = "R9 tick gating";
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); tick = (i % 3 == 0);
    end
    @(negedge clk); tick = 1'b1;
    phase = "R10 write at match";
    wr(0, 7); wr(1, 4);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (m_cnt == m_buf[0]) break;
    end
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd2;
    @(negedge clk); wr_en = 1'b0;
    idle(25);
    phase = "R8 stopped";
    @(negedge clk); run = 1'b0;
    idle(4);
    phase = "R6 ignored write";
    wr(0, 3); wr(2, 1);
    idle(2);
    phase = "R7 restart with write";
    @(negedge clk); run = 1'b1;
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd6;
    @(negedge clk); wr_en = 1'b0;
    idle(30);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule